// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is an eight-stage register that can keep its value, move its contents one place in either direction, or capture a full byte in parallel. The same byte-wide bus is used to load the register and to read it back. The tri-state bus is modelled as three separate signals: an input byte, an output byte and a per-bit drive-enable vector. A pad ring outside the block combines them into a real bidirectional pin.

State changes only on the rising clock edge. The exception is an active-low clear, which empties every stage at once without waiting for a clock. Two active-low enables decide whether the register drives the bus. While a parallel load is selected, the block never drives the bus, so an external source can present the byte to be captured. Two serial outputs, one from each end stage, are always driven. This lets several blocks be chained in either direction while the bus is released.

Stage A is bit 0 and stage H is bit 7 of every byte-wide port.

Top module: `usr_shift_bus`

## Requirements
- R1: `mode_sel` selects the action taken at a rising clock edge: 2'b00 keeps the contents unchanged, 2'b01 shifts toward H, 2'b10 shifts toward A, and 2'b11 loads in parallel.
- R2: A low level on `clr_n` forces all stages to 0 at once, without a clock edge. While clear is low, `data_out`, `ser_a_out` and `ser_h_out` read 0.
- R3: The contents change only on a rising edge of `clk` while `clr_n` is high. Input changes between edges have no effect, and a rising edge while clear is low leaves every stage at 0.
- R4: In the shift toward H (2'b01), bit 0 takes `ser_r_in` and each bit i above 0 takes the previous value of bit i-1.
- R5: In the shift toward A (2'b10), bit 7 takes `ser_l_in` and each bit i below 7 takes the previous value of bit i+1.
- R6: In parallel load (2'b11), the register takes the value of `bus_in` at the clock edge.
- R7: `bus_oe` is all ones only when `oe1_n` and `oe2_n` are both low and `mode_sel` is not 2'b11. Otherwise it is all zeros.
- R8: The levels of `oe1_n` and `oe2_n` have no effect on holding, shifting, loading or clearing.
- R9: `ser_a_out` always equals bit 0 and `ser_h_out` always equals bit 7 of the contents, whatever the enables are.
- R10: `data_out` always carries the register contents, whether or not the bus is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state is updated on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | Action select: hold, shift toward H, shift toward A, load |
| oe1_n | input | 1 | First bus drive enable, active low |
| oe2_n | input | 1 | Second bus drive enable, active low |
| ser_r_in | input | 1 | Serial input entering stage A during the shift toward H |
| ser_l_in | input | 1 | Serial input entering stage H during the shift toward A |
| bus_in | input | 8 | Level seen on the shared bus; captured during load |
| data_out | output | 8 | Register contents presented for the bus |
| bus_oe | output | 8 | Per-bit bus drive enable |
| ser_a_out | output | 1 | Stage A, always driven |
| ser_h_out | output | 1 | Stage H, always driven |

## Verification
Two things can fall in the same cycle: the asynchronous clear and a clocked shift or load. To provoke this, clear is dropped a few nanoseconds after a rising edge while the bus is enabled. The outputs are read before the next edge and must already be zero. A load edge is then let pass with clear still held, and the contents must remain zero. Random sequences also pulse clear across edges and toggle both enables during shifting. Every cycle is compared with a bench model built from the mode encoding, which also checks that the bus enable drops in load mode and that the serial ends stay live.

// File: rtl/usr_pkg.sv
// Shared definitions for the universal shift register.
// Assumes stage A maps to bit 0 and stage H to the top bit.
package usr_pkg;
    localparam int unsigned USR_STAGES = 8;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;
endpackage

// File: rtl/usr_mode_decode.sv
// Turns the two-bit action select into one strobe per action.
// Assumes mode_sel is stable around the clock edge; exactly one strobe is high.
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic [1:0] mode_sel,
    output logic       do_hold,
    output logic       do_shr,
    output logic       do_shl,
    output logic       do_load
);
    usr_mode_e mode;

    // Decode the select into action strobes.
    always_comb begin
        mode    = usr_mode_e'(mode_sel);
        do_hold = (mode == MODE_HOLD);
        do_shr  = (mode == MODE_SHR);
        do_shl  = (mode == MODE_SHL);
        do_load = (mode == MODE_LOAD);
    end
endmodule

// File: rtl/usr_stage_bank.sv
// The storage stages and the next-value selection for each of them.
// Assumes at most one action strobe is high. clr_n clears asynchronously;
// otherwise every stage updates on the rising clock edge.
module usr_stage_bank #(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              do_hold,
    input  logic              do_shr,
    input  logic              do_shl,
    input  logic              do_load,
    input  logic              ser_r,
    input  logic              ser_l,
    input  logic [STAGES-1:0] par_in,
    output logic [STAGES-1:0] q
);
    localparam int unsigned TOP = STAGES - 1;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic from_low;
        logic from_high;
        logic nxt;

        if (i == 0) begin : g_first
            assign from_low = ser_r;
        end else begin : g_low
            assign from_low = q[i-1];
        end

        if (i == TOP) begin : g_last
            assign from_high = ser_l;
        end else begin : g_high
            assign from_high = q[i+1];
        end

        // Pick this stage's next value from the active strobe.
        always_comb begin
            if (do_load)     nxt = par_in[i];
            else if (do_shr) nxt = from_low;
            else if (do_shl) nxt = from_high;
            else             nxt = q[i];
        end

        // Store the stage value; clear overrides the clock.
        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) q[i] <= 1'b0;
            else        q[i] <= nxt;
        end
    end

    // R2: clear holds every stage at zero
    p_clear_empty_r2: assert property (@(posedge clk) !clr_n |-> (q == '0));

    // R1: hold keeps the contents
    p_hold_keep_r1: assert property (@(posedge clk) disable iff (!clr_n)
        do_hold |=> (q == $past(q)));

    // R4: shift toward H
    p_shift_high_r4: assert property (@(posedge clk) disable iff (!clr_n)
        do_shr |=> (q == {$past(q[TOP-1:0]), $past(ser_r)}));

    // R5: shift toward A
    p_shift_low_r5: assert property (@(posedge clk) disable iff (!clr_n)
        do_shl |=> (q == {$past(ser_l), $past(q[TOP:1])}));

    // R6: parallel capture
    p_load_take_r6: assert property (@(posedge clk) disable iff (!clr_n)
        do_load |=> (q == $past(par_in)));
endmodule

// File: rtl/usr_bus_ctrl.sv
// Works out when the register drives the shared bus.
// Assumes both enables are active low. Load mode always releases the bus.
module usr_bus_ctrl #(
    parameter int unsigned STAGES = 8
) (
    input  logic              oe1_n,
    input  logic              oe2_n,
    input  logic              do_load,
    output logic [STAGES-1:0] bus_oe
);
    logic drive;

    // Drive only with both enables active and no load in progress.
    always_comb begin
        drive  = !oe1_n && !oe2_n && !do_load;
        bus_oe = {STAGES{drive}};
    end
endmodule

// File: rtl/usr_shift_bus.sv
// Top level of the universal shift register with a shared parallel bus.
// The tri-state bus is modelled as bus_in, data_out and bus_oe. A pad ring
// outside this block forms the real pin. The serial end outputs are never released.
module usr_shift_bus
    import usr_pkg::*;
#(
    parameter int unsigned STAGES = USR_STAGES
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic [1:0]        mode_sel,
    input  logic              oe1_n,
    input  logic              oe2_n,
    input  logic              ser_r_in,
    input  logic              ser_l_in,
    input  logic [STAGES-1:0] bus_in,
    output logic [STAGES-1:0] data_out,
    output logic [STAGES-1:0] bus_oe,
    output logic              ser_a_out,
    output logic              ser_h_out
);
    localparam int unsigned TOP = STAGES - 1;

    logic              do_hold, do_shr, do_shl, do_load;
    logic [STAGES-1:0] q;

    usr_mode_decode u_decode (
        .mode_sel (mode_sel),
        .do_hold  (do_hold),
        .do_shr   (do_shr),
        .do_shl   (do_shl),
        .do_load  (do_load)
    );

    usr_stage_bank #(.STAGES(STAGES)) u_bank (
        .clk     (clk),
        .clr_n   (clr_n),
        .do_hold (do_hold),
        .do_shr  (do_shr),
        .do_shl  (do_shl),
        .do_load (do_load),
        .ser_r   (ser_r_in),
        .ser_l   (ser_l_in),
        .par_in  (bus_in),
        .q       (q)
    );

    usr_bus_ctrl #(.STAGES(STAGES)) u_bus (
        .oe1_n   (oe1_n),
        .oe2_n   (oe2_n),
        .do_load (do_load),
        .bus_oe  (bus_oe)
    );

    // Present the contents on the bus data and the two serial ends.
    always_comb begin
        data_out  = q;
        ser_a_out = q[0];
        ser_h_out = q[TOP];
    end

    // R7: bus released when disabled or loading
    p_bus_release_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (oe1_n || oe2_n || (mode_sel == 2'b11)) |-> (bus_oe == '0));

    // R7: bus driven when both enables active outside load
    p_bus_drive_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (!oe1_n && !oe2_n && (mode_sel != 2'b11)) |-> (bus_oe == '1));
endmodule

// File: tb/tb_usr_shift_bus.sv
// Self-checking bench: a vector table, directed clear and edge cases,
// then random sequences compared against a model.
module tb_usr_shift_bus;
    logic       clk = 1'b0;
    logic       clr_n;
    logic [1:0] mode_sel;
    logic       oe1_n, oe2_n, ser_r_in, ser_l_in;
    logic [7:0] bus_in;
    logic [7:0] data_out, bus_oe;
    logic       ser_a_out, ser_h_out;

    int compared   = 0;
    int mismatched = 0;
    logic [7:0] ref_q;

    usr_shift_bus dut (
        .clk       (clk),
        .clr_n     (clr_n),
        .mode_sel  (mode_sel),
        .oe1_n     (oe1_n),
        .oe2_n     (oe2_n),
        .ser_r_in  (ser_r_in),
        .ser_l_in  (ser_l_in),
        .bus_in    (bus_in),
        .data_out  (data_out),
        .bus_oe    (bus_oe),
        .ser_a_out (ser_a_out),
        .ser_h_out (ser_h_out)
    );

    always #4 clk = ~clk;

    // Vector: mode, ser_r, ser_l, oe1_n, oe2_n, bus_in, expected q, expected bus_oe
    localparam int NVEC = 10;
    localparam logic [29:0] VEC [NVEC] = '{
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 8'h00},
        {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA5, 8'hFF},
        {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h4B, 8'hFF},
        {2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h96, 8'h00},
        {2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'hCB, 8'h00},
        {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h65, 8'hFF},
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 8'h00},
        {2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h3C, 8'h00},
        {2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h1E, 8'hFF},
        {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3D, 8'hFF}
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req, input logic [7:0] eq, input logic [7:0] eoe);
        check8({req, " data_out (R10)"}, data_out, eq);
        check8({req, " bus_oe (R7)"}, bus_oe, eoe);
        check8({req, " serial ends (R9)"}, {6'd0, ser_h_out, ser_a_out}, {6'd0, eq[7], eq[0]});
    endtask

    function automatic logic [7:0] model_oe(input logic [1:0] m, input logic e1, input logic e2);
        return (!e1 && !e2 && m != 2'b11) ? 8'hFF : 8'h00;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_000_000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        clr_n = 1'b0; mode_sel = 2'b00; oe1_n = 1'b0; oe2_n = 1'b0;
        ser_r_in = 1'b0; ser_l_in = 1'b0; bus_in = 8'h00;
        repeat (2) @(negedge clk);
        // R2: reset state
        check_all("R2 reset", 8'h00, 8'hFF);
        clr_n = 1'b1;

        // Table walk: R1 R4 R5 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {mode_sel, ser_r_in, ser_l_in, oe1_n, oe2_n, bus_in} = VEC[i][29:16];
            @(posedge clk); #2;
            check_all($sformatf("R1/R4/R5/R6 vector %0d", i), VEC[i][15:8], VEC[i][7:0]);
        end

        // R3: inputs change between edges without effect (contents 3D)
        @(negedge clk);
        mode_sel = 2'b11; bus_in = 8'h81;
        #1; check8("R3 no change before edge", data_out, 8'h3D);
        @(posedge clk); #2;
        check8("R6 load after edge", data_out, 8'h81);

        // R2: clear mid-cycle with bus enabled, immediate effect
        @(negedge clk);
        mode_sel = 2'b00; oe1_n = 1'b0; oe2_n = 1'b0;
        @(posedge clk); #2;
        clr_n = 1'b0;
        #1; check_all("R2 async clear mid-cycle", 8'h00, 8'hFF);
        // R3: a load edge while clear is held leaves zeros
        mode_sel = 2'b11; bus_in = 8'hFF;
        @(posedge clk); #2;
        check8("R3 edge under clear", data_out, 8'h00);
        @(negedge clk); clr_n = 1'b1; mode_sel = 2'b11; bus_in = 8'h7E;
        @(posedge clk); #2;
        check8("R6 load after clear", data_out, 8'h7E);

        // R8: clear with both enables inactive still empties stages
        @(negedge clk); oe1_n = 1'b1; oe2_n = 1'b1; mode_sel = 2'b00; #1;
        clr_n = 1'b0;
        #1; check_all("R8 clear with bus released", 8'h00, 8'h00);
        @(negedge clk); clr_n = 1'b1;

        // Random sequences against the model: R1 R2 R4 R5 R6 R7 R8
        ref_q = 8'h00;
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            mode_sel = 2'($urandom); oe1_n = 1'($urandom); oe2_n = 1'($urandom);
            ser_r_in = 1'($urandom); ser_l_in = 1'($urandom); bus_in = 8'($urandom);
            clr_n = (($urandom % 16) != 0);
            @(posedge clk); #2;
            if (!clr_n) ref_q = 8'h00;
            else begin
                case (mode_sel)
                    2'b01:   ref_q = {ref_q[6:0], ser_r_in};
                    2'b10:   ref_q = {ser_l_in, ref_q[7:1]};
                    2'b11:   ref_q = bus_in;
                    default: ref_q = ref_q;
                endcase
            end
            check_all("R1/R4/R5/R6/R8 random", ref_q, model_oe(mode_sel, oe1_n, oe2_n));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule